// File: doc/BRIEF.md
# Real-Time Clock with Staged Load and Live Count Registers

This block keeps time as a binary seconds counter paired with a sixteenths-of-a-second sub-counter. A free-running 16 Hz tick enable advances the count while the clock is enabled. Software talks to it through a byte-wide register bus that has a single address.

To set the time, software first writes the new value into a set of staging registers. It then raises the commit bit in the control register, and the staged value is copied into the live counters in a single step. Counting carries on from that value.

The live registers are read-only. Reading the most significant live seconds byte freezes a copy of the entire count. The remaining live bytes are then read from that copy, so a multi-byte read stays consistent while ticks continue. Clearing the enable bit stops the count and wipes the staged seconds.

With NB = SEC_W/8, the register layout is as follows. Staged seconds occupy offsets 0..NB-1, most significant byte first. Staged sixteenths sit at offset NB. Live sixteenths sit at NB+1. Live seconds occupy NB+2..2NB+1, most significant byte first. Control sits at 2NB+2.

Top module: `rtc_loadcount`

## Requirements
- R1: A write to staged seconds offset i (0..NB-1) stores the byte as bits [SEC_W-1-8i -: 8] of the staged seconds, and reading that offset returns the byte that was written.
- R2: Staged sixteenths at offset NB keep only the low SUB_W bits of a write. The upper bits of that byte, and of the live sixteenths byte at NB+1, always read as zero.
- R3: Writes to the live offsets NB+1..2NB+1 have no effect on the count.
- R4: The control register at offset 2NB+2 stores only write bits 1..0 (bit 0 = enable, bit 1 = commit). Reading it returns bit 7 = 1, bits 6..2 = 0 and the stored bits 1..0.
- R5: Any control write with bit 0 = 0 clears the staged seconds to zero. Staged sixteenths are unaffected.
- R6: A control write with bit 0 = 1 and bit 1 = 1, made while the stored bit 1 is 0, copies the staged seconds and sixteenths into the live count at that clock edge. A write made while the stored bit 1 is already 1 copies nothing.
- R7: Each tick while enabled increments the sixteenths. A 15-to-0 wrap of the sixteenths increments the seconds, which wrap modulo 2^SEC_W.
- R8: While disabled, ticks are ignored and the live count holds its value.
- R9: A read of the live seconds MSB (offset NB+2) returns the live byte and captures the whole count. Reads of the live sixteenths and the lower live seconds bytes return the captured values.
- R10: Read data appears on the clock edge after the read request and is zero in any cycle without a read. Unmapped offsets read zero. After reset all registers are zero, so control reads 0x80.
- R11: When a commit and a tick fall on the same edge, the committed value is loaded and the tick is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_16hz | input | 1 | One-cycle pulse, 16 per second |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register offset |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte, valid the cycle after rd_en |

## Verification
The bench builds the block with SEC_W = 16 and SUB_W = 4. This makes the full count 20 bits wide, so commits close to the top of the seconds range followed by a run of ticks reach the seconds wrap to zero within a few dozen cycles. Commits are swept over every sixteenths value against a set of seconds values that includes 0xFFFF and 0xFFFE. The expected count is computed arithmetically modulo 2^20 after each run of ticks.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    typedef logic [7:0] byte_t;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_CMT_BIT = 1;

    function automatic byte_t ctrl_readback(input logic [1:0] bits);
        return {1'b1, 5'b00000, bits};
    endfunction
endpackage

// File: rtl/rtc_stage_regs.sv
module rtc_stage_regs
    import rtc_pkg::*;
#(
    parameter int SEC_W  = 32,
    parameter int SUB_W  = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  byte_t             wr_data,
    output logic [SEC_W-1:0]  stg_sec,
    output logic [SUB_W-1:0]  stg_sub,
    output logic [1:0]        ctrl,
    output logic              commit
);
    localparam int NB        = SEC_W / 8;
    localparam int STG_SUB_A = NB;
    localparam int CTRL_A    = 2 * NB + 2;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [SUB_W-1:0] sub;
        logic [1:0]       ctrl;
    } stage_t;

    stage_t st_d, st_q;
    logic   commit_d;

    always_comb begin
        st_d     = st_q;
        commit_d = 1'b0;
        if (wr_en) begin
            for (int i = 0; i < NB; i++) begin
                if (addr == ADDR_W'(i))
                    st_d.sec[SEC_W-1-8*i -: 8] = wr_data;
            end
            if (addr == ADDR_W'(STG_SUB_A))
                st_d.sub = wr_data[SUB_W-1:0];
            if (addr == ADDR_W'(CTRL_A)) begin
                st_d.ctrl = wr_data[1:0];
                if (!wr_data[CTRL_EN_BIT])
                    st_d.sec = '0;
                commit_d = wr_data[CTRL_EN_BIT] && wr_data[CTRL_CMT_BIT]
                           && !st_q.ctrl[CTRL_CMT_BIT];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stg_sec = st_q.sec;
    assign stg_sub = st_q.sub;
    assign ctrl    = st_q.ctrl;
    assign commit  = commit_d;

    p_disable_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(CTRL_A) && !wr_data[0]) |=> (stg_sec == '0));
    p_sub_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(CTRL_A)) |=> $stable(stg_sub));
    p_commit_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> ctrl[1]);
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
    parameter int SEC_W = 32,
    parameter int SUB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             en,
    input  logic             commit,
    input  logic [SEC_W-1:0] ld_sec,
    input  logic [SUB_W-1:0] ld_sub,
    output logic [SEC_W-1:0] cnt_sec,
    output logic [SUB_W-1:0] cnt_sub
);
    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [SUB_W-1:0] sub;
    } count_t;

    count_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (commit) begin
            c_d.sec = ld_sec;
            c_d.sub = ld_sub;
        end else if (en && tick) begin
            c_d.sub = c_q.sub + SUB_W'(1);
            if (c_q.sub == '1)
                c_d.sec = c_q.sec + SEC_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cnt_sec = c_q.sec;
    assign cnt_sub = c_q.sub;

    p_commit_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (cnt_sec == $past(ld_sec) && cnt_sub == $past(ld_sub)));
    p_wrap_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && !commit && cnt_sub == '1)
        |=> (cnt_sub == '0 && cnt_sec == $past(cnt_sec) + SEC_W'(1)));
    p_sub_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && !commit && cnt_sub != '1)
        |=> (cnt_sub == $past(cnt_sub) + SUB_W'(1) && $stable(cnt_sec)));
    p_hold_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !commit) |=> ($stable(cnt_sec) && $stable(cnt_sub)));
endmodule

// File: rtl/rtc_readout.sv
module rtc_readout
    import rtc_pkg::*;
#(
    parameter int SEC_W  = 32,
    parameter int SUB_W  = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SEC_W-1:0]  stg_sec,
    input  logic [SUB_W-1:0]  stg_sub,
    input  logic [1:0]        ctrl,
    input  logic [SEC_W-1:0]  cnt_sec,
    input  logic [SUB_W-1:0]  cnt_sub,
    output byte_t             rd_data
);
    localparam int NB         = SEC_W / 8;
    localparam int STG_SUB_A  = NB;
    localparam int LIVE_SUB_A = NB + 1;
    localparam int LIVE_SEC_A = NB + 2;
    localparam int CTRL_A     = 2 * NB + 2;

    typedef struct packed {
        logic [SEC_W-1:0] snap_sec;
        logic [SUB_W-1:0] snap_sub;
        byte_t            rdata;
    } rd_t;

    rd_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.rdata = '0;
        if (rd_en) begin
            for (int i = 0; i < NB; i++) begin
                if (addr == ADDR_W'(i))
                    r_d.rdata = stg_sec[SEC_W-1-8*i -: 8];
                if (addr == ADDR_W'(LIVE_SEC_A + i))
                    r_d.rdata = (i == 0) ? cnt_sec[SEC_W-1 -: 8]
                                         : r_q.snap_sec[SEC_W-1-8*i -: 8];
            end
            if (addr == ADDR_W'(STG_SUB_A))
                r_d.rdata = byte_t'(stg_sub);
            if (addr == ADDR_W'(LIVE_SUB_A))
                r_d.rdata = byte_t'(r_q.snap_sub);
            if (addr == ADDR_W'(CTRL_A))
                r_d.rdata = ctrl_readback(ctrl);
            if (addr == ADDR_W'(LIVE_SEC_A)) begin
                r_d.snap_sec = cnt_sec;
                r_d.snap_sub = cnt_sub;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rd_data = r_q.rdata;

    p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rd_data == '0));
    p_ctrl_bit7_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(CTRL_A)) |=> (rd_data[7] && rd_data[6:2] == '0));
    p_sub_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr == ADDR_W'(STG_SUB_A) || addr == ADDR_W'(LIVE_SUB_A)))
        |=> (rd_data >> SUB_W) == '0);
    p_msb_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(LIVE_SEC_A))
        |=> (rd_data == $past(cnt_sec[SEC_W-1 -: 8])));
endmodule

// File: rtl/rtc_loadcount.sv
module rtc_loadcount
    import rtc_pkg::*;
#(
    parameter int SEC_W  = 32,
    parameter int SUB_W  = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_16hz,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data
);
    localparam int NB = SEC_W / 8;

    initial begin
        assert (SEC_W % 8 == 0 && SEC_W >= 8) else $error("SEC_W must be whole bytes");
        assert (SUB_W >= 1 && SUB_W <= 8) else $error("SUB_W out of range");
        assert ((2 * NB + 3) <= (1 << ADDR_W)) else $error("ADDR_W too small");
    end

    logic [SEC_W-1:0] stg_sec, cnt_sec;
    logic [SUB_W-1:0] stg_sub, cnt_sub;
    logic [1:0]       ctrl;
    logic             commit;

    rtc_stage_regs #(.SEC_W(SEC_W), .SUB_W(SUB_W), .ADDR_W(ADDR_W)) u_stage (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .stg_sec(stg_sec), .stg_sub(stg_sub), .ctrl(ctrl), .commit(commit)
    );

    rtc_counter #(.SEC_W(SEC_W), .SUB_W(SUB_W)) u_count (
        .clk(clk), .rst_n(rst_n), .tick(tick_16hz), .en(ctrl[CTRL_EN_BIT]),
        .commit(commit), .ld_sec(stg_sec), .ld_sub(stg_sub),
        .cnt_sec(cnt_sec), .cnt_sub(cnt_sub)
    );

    rtc_readout #(.SEC_W(SEC_W), .SUB_W(SUB_W), .ADDR_W(ADDR_W)) u_read (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr),
        .stg_sec(stg_sec), .stg_sub(stg_sub), .ctrl(ctrl),
        .cnt_sec(cnt_sec), .cnt_sub(cnt_sub), .rd_data(rd_data)
    );

    p_tick_priority_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && tick_16hz) |=> (cnt_sec == $past(stg_sec) && cnt_sub == $past(stg_sub)));
endmodule

// File: tb/rtc_loadcount_tb.sv
module rtc_loadcount_tb;
    localparam int SEC_W = 16;
    localparam int SUB_W = 4;
    localparam int ADDR_W = 8;
    localparam int TOT_W = SEC_W + SUB_W;
    localparam int A_SSUB = 2, A_LSUB = 3, A_LMSB = 4, A_LLSB = 5, A_CTRL = 6;

    logic clk = 0, rst_n = 0, tick = 0, wr_en = 0, rd_en = 0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0] wr_data = '0, rd_data;
    int n_chk = 0, n_bad = 0, cyc = 0;

    logic [TOT_W-1:0] m_cnt = '0;
    logic m_en = 0;

    rtc_loadcount #(.SEC_W(SEC_W), .SUB_W(SUB_W), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_16hz(tick), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data));

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk); wr_en = 1; addr = ADDR_W'(a); wr_data = 8'(d);
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input int a, output int v);
        @(negedge clk); rd_en = 1; addr = ADDR_W'(a);
        @(negedge clk); rd_en = 0; v = int'(rd_data);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1;
            @(negedge clk); tick = 0;
            if (m_en) m_cnt = m_cnt + 1'b1;
        end
    endtask

    task automatic read_live(output int total);
        int h, l, s;
        rd(A_LMSB, h); rd(A_LLSB, l); rd(A_LSUB, s);
        total = (((h << 8) | l) << 4) | s;
    endtask

    task automatic stage(input int sec, input int sub);
        wr(0, sec >> 8); wr(1, sec & 255); wr(A_SSUB, sub);
    endtask

    initial begin
        int v, t;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R10: reset state
        rd(A_CTRL, v); chk("R10 ctrl reset", v, 8'h80);
        rd(0, v); chk("R10 staged reset", v, 0);
        read_live(t); chk("R10 live reset", t, 0);
        rd(7, v); chk("R10 unmapped 7", v, 0);
        rd(255, v); chk("R10 unmapped 255", v, 0);

        // R1: staged seconds byte sweep
        for (int b = 0; b < 256; b += 17) begin
            wr(0, b); wr(1, 255 - b);
            rd(0, v); chk("R1 staged msb", v, b);
            rd(1, v); chk("R1 staged lsb", v, 255 - b);
        end

        // R2: staged sixteenths masked
        wr(A_SSUB, 8'hA7); rd(A_SSUB, v); chk("R2 staged sub", v, 7);

        // R3: writes to live registers ignored
        wr(A_LSUB, 8'h55); wr(A_LMSB, 8'h55); wr(A_LLSB, 8'h55);
        read_live(t); chk("R3 live unchanged", t, 0);

        // R8: ticks while disabled
        ticks(5); read_live(t); chk("R8 disabled ticks", t, 0);

        // R4 / R5: control readback and clear of staged seconds
        wr(0, 8'h12); wr(1, 8'h34);
        wr(A_CTRL, 8'hFE); rd(A_CTRL, v); chk("R4 ctrl readback", v, 8'h82);
        rd(0, v); chk("R5 staged msb cleared", v, 0);
        rd(1, v); chk("R5 staged lsb cleared", v, 0);
        rd(A_SSUB, v); chk("R5 staged sub kept", v, 7);
        wr(A_CTRL, 8'h00);
        read_live(t); chk("R6 no commit without enable", t, 0);

        // R6 / R7: commit sweep with tick runs
        for (int k = 0; k < 5; k++) begin
            int sv;
            case (k)
                0: sv = 16'h0000; 1: sv = 16'h00FF; 2: sv = 16'h7FFF;
                3: sv = 16'hFFFE; default: sv = 16'hFFFF;
            endcase
            for (int s = 0; s < 16; s++) begin
                int n;
                stage(sv, s);
                wr(A_CTRL, 8'h01); m_en = 1;
                wr(A_CTRL, 8'h03); m_cnt = TOT_W'((sv << 4) | s);
                read_live(t); chk("R6 commit value", t, int'(m_cnt));
                n = (s * 3 + k) % 20 + 1;
                ticks(n);
                read_live(t); chk("R7 count after ticks", t, int'(m_cnt));
            end
        end

        // R6: re-write with commit bit already set copies nothing
        stage(16'h1234, 9);
        wr(A_CTRL, 8'h03);
        read_live(t); chk("R6 no commit when bit1 held", t, int'(m_cnt));

        // R11: commit and tick on the same edge
        wr(A_CTRL, 8'h01);
        @(negedge clk); wr_en = 1; addr = A_CTRL; wr_data = 8'h03; tick = 1;
        @(negedge clk); wr_en = 0; tick = 0;
        m_cnt = TOT_W'((16'h1234 << 4) | 9);
        read_live(t); chk("R11 commit beats tick", t, int'(m_cnt));

        // R8: disable holds count
        wr(A_CTRL, 8'h00); m_en = 0;
        ticks(10);
        read_live(t); chk("R8 hold when disabled", t, int'(m_cnt));
        rd(0, v); chk("R5 staged cleared on disable", v, 0);

        // R9: snapshot consistency
        wr(A_CTRL, 8'h01); m_en = 1;
        ticks(3);
        begin
            logic [TOT_W-1:0] snap;
            int h, l, s;
            snap = m_cnt;
            rd(A_LMSB, h);
            ticks(40);
            rd(A_LLSB, l); rd(A_LSUB, s);
            chk("R9 snapshot msb", h, int'(snap[TOT_W-1 -: 8]));
            chk("R9 snapshot lsb", l, int'(snap[11:4]));
            chk("R9 snapshot sub", s, int'(snap[3:0]));
            read_live(t); chk("R9 fresh snapshot", t, int'(m_cnt));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule